// File: doc/BRIEF.md
# Debug Scan-Chain Register Access Unit

This block is the data-register side of a debug scan chain. An external debugger shifts 38-bit packets through it over the test clock. Each packet holds a 32-bit data word, a 5-bit register address and a direction flag. The block decodes the packet and either writes one of a small bank of 32-bit debug registers or reads one back. The bank holds debug control, debug status, vector catch, two watch units of six words each, and a pair of one-word mailboxes between the debugger and the core.

A read is pipelined. The scan that carries the read request only names the register. The next Capture-DR loads that register's value into the shift register, and the scan after the request shifts it out. A write takes effect on Update-DR.

The core side is clocked by the same test clock. It sees:
- the control, vector-catch and watch words as plain outputs;
- debug status as a plain input;
- the mailboxes as valid/ready streams.

On the outbound stream (debugger to core), `h2c_valid` stays high and `h2c_data` stays stable until the core raises `h2c_ready`. On the inbound stream (core to debugger), `c2h_ready` is high only while the one-word slot is empty. A word pushed while `c2h_ready` is low is not taken.

Top module: `dbg_scan_regbank`

## Requirements
- R1: While `sel` and `shift_dr` are high, each rising `tck` edge shifts `tdi` into bit 37 and moves the 38-bit register one place toward bit 0. `tdo` always shows bit 0. Bits 31:0 are data, bits 36:32 are the address and bit 37 is the direction, so data goes in first, LSB first.
- R2: On a rising edge with `sel` and `update_dr` high, a packet whose direction bit is 1 writes its data to the register at its address.
- R3: A packet whose direction bit is 0 is a read request. On the next selected Capture-DR the shift register loads {direction 0, that address, that register's value}, which is shifted out in that scan. A Capture-DR with no pending request loads all zeros.
- R4: Debug control (address 0x00) holds 6 bits, with bit 4 as the monitor-mode enable. It drives `dbg_ctrl_o` and reads back zero-extended.
- R5: Debug status (address 0x01) reads `dbg_status_i` zero-extended. Writes to it have no effect.
- R6: Vector catch (address 0x02) holds `VC_W` (8) bits. It drives `vcat_o` and reads back zero-extended.
- R7: Watch unit u sits at addresses 8·(u+1)+f, with f from 0 to 5 in the order address value, address mask, data value, data mask, control value, control mask. Slot 6u+f is stored in full and appears on `wp_cfg_o[32(6u+f) +: 32]`.
- R8: Addresses 0x03, 0x06, 0x07, 0x0E, 0x0F, 0x16 to 0x1F read as zero, and writes to them change nothing. Scans made with `sel` low change nothing.
- R9: A write to comms data (0x05) fills the outbound slot when it is empty, raising `h2c_valid` with the word on `h2c_data`. A write to 0x05 while the slot is still full is ignored. The slot empties on an `h2c_valid`/`h2c_ready` handshake.
- R10: The inbound slot takes `c2h_data` when `c2h_valid` and `c2h_ready` are both high. A read of 0x05 returns the held word and empties the slot at its Capture-DR, so `c2h_ready` returns to 1.
- R11: Comms control (0x04) reads bit 0 = outbound slot full and bit 1 = inbound slot full, with all other bits zero. Writes to it have no effect.
- R12: After `trst_n` is low: `tdo`, `dbg_ctrl_o`, `vcat_o`, `wp_cfg_o` and `h2c_valid` are 0, and `c2h_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; clocks the whole block |
| trst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | This chain is the active data register |
| capture_dr | input | 1 | TAP Capture-DR strobe |
| shift_dr | input | 1 | TAP Shift-DR strobe |
| update_dr | input | 1 | TAP Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the shift register |
| dbg_status_i | input | 5 | Core debug status, read at 0x01 |
| dbg_ctrl_o | output | 6 | Debug control register |
| vcat_o | output | VC_W | Vector catch register |
| wp_cfg_o | output | NUM_WATCH·192 | All watch-unit words, slot k at bits 32k+31:32k |
| h2c_valid | output | 1 | Debugger-to-core word available |
| h2c_ready | input | 1 | Core takes the debugger-to-core word |
| h2c_data | output | 32 | Debugger-to-core word |
| c2h_valid | input | 1 | Core offers a word to the debugger |
| c2h_ready | output | 1 | Inbound slot empty, word accepted |
| c2h_data | input | 32 | Core-to-debugger word |

## Verification
A wrong shift or decode state shows at `tdo` one full scan after the fault, because any read value appears only in the scan after the request. The bench therefore checks the address and direction echoed in that scan as well as the data. A mis-decoded write shows on the register outputs from the cycle after Update-DR, or as zero instead of the expected value on the next read-back. Mailbox faults show as `h2c_valid` or `c2h_ready` in the wrong state on the cycle after the scan edge that should have changed them.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int PKT_W  = DATA_W + ADDR_W + 1;
  localparam int CTRL_W = 6;
  localparam int STAT_W = 5;
  localparam int WORDS_PER_UNIT = 6;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h01;
  localparam logic [ADDR_W-1:0] A_VCAT = 5'h02;
  localparam logic [ADDR_W-1:0] A_CCTL = 5'h04;
  localparam logic [ADDR_W-1:0] A_CDAT = 5'h05;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } pkt_t;

  function automatic logic [ADDR_W-1:0] slot_addr(input int k);
    return ADDR_W'((k / WORDS_PER_UNIT + 1) * 8 + (k % WORDS_PER_UNIT));
  endfunction
endpackage

// File: rtl/dbg_shift_chain.sv
module dbg_shift_chain
  import dbg_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              capture,
  input  logic              shift,
  input  logic              update,
  input  logic              tdi,
  output logic              tdo,
  input  logic [DATA_W-1:0] cap_data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_take
);
  pkt_t              sr;
  logic              rd_pend;
  logic [ADDR_W-1:0] rd_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      rd_pend   <= 1'b0;
      rd_addr_q <= '0;
    end else if (sel && capture) begin
      sr        <= rd_pend ? pkt_t'({1'b0, rd_addr_q, cap_data}) : '0;
      rd_pend   <= 1'b0;
    end else if (sel && shift) begin
      sr        <= pkt_t'({tdi, sr[PKT_W-1:1]});
    end else if (sel && update) begin
      rd_pend   <= !sr.wr;
      rd_addr_q <= sr.addr;
    end
  end

  assign tdo     = sr[0];
  assign wr_stb  = sel && update && sr.wr;
  assign wr_addr = sr.addr;
  assign wr_data = sr.data;
  assign rd_addr = rd_addr_q;
  assign rd_take = sel && capture && rd_pend;

  assert_shift_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && shift && !capture) |=> (sr[PKT_W-2:0] == $past(sr[PKT_W-1:1])));

  assert_idle_capture_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && capture && !rd_pend) |=> (sr == '0));

  assert_capture_is_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && capture) |=> !sr.wr);
endmodule

// File: rtl/dbg_mbox_slot.sv
module dbg_mbox_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full;
  logic [W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else if (full) begin
      if (out_ready) full <= 1'b0;
    end else if (in_valid) begin
      full <= 1'b1;
      word <= in_data;
    end
  end

  assign in_ready  = !full;
  assign out_valid = full;
  assign out_data  = word;

  // R9 / R10: a held word stays put until it is released
  assert_slot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !out_ready) |=> (full && $stable(word)));
endmodule

// File: rtl/dbg_reg_file.sv
module dbg_reg_file
  import dbg_scan_pkg::*;
#(
  parameter int NUM_WATCH = 2,
  parameter int VC_W      = 8
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     wr_stb,
  input  logic [ADDR_W-1:0]                        wr_addr,
  input  logic [DATA_W-1:0]                        wr_data,
  input  logic [ADDR_W-1:0]                        rd_addr,
  output logic [DATA_W-1:0]                        rd_data,
  input  logic [STAT_W-1:0]                        status_i,
  input  logic                                     out_full,
  input  logic                                     in_full,
  input  logic [DATA_W-1:0]                        in_word,
  output logic [CTRL_W-1:0]                        ctrl_o,
  output logic [VC_W-1:0]                          vcat_o,
  output logic [NUM_WATCH*WORDS_PER_UNIT*DATA_W-1:0] wp_cfg_o
);
  localparam int NSLOT = NUM_WATCH * WORDS_PER_UNIT;

  logic [CTRL_W-1:0] ctrl_q;
  logic [VC_W-1:0]   vcat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      vcat_q <= '0;
    end else if (wr_stb) begin
      if (wr_addr == A_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
      if (wr_addr == A_VCAT) vcat_q <= wr_data[VC_W-1:0];
    end
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam logic [ADDR_W-1:0] SA = slot_addr(k);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         q <= '0;
      else if (wr_stb && wr_addr == SA)   q <= wr_data;
    end
    assign wp_cfg_o[k*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data[CTRL_W-1:0] = ctrl_q;
      A_STAT: rd_data[STAT_W-1:0] = status_i;
      A_VCAT: rd_data[VC_W-1:0]   = vcat_q;
      A_CCTL: rd_data[1:0]        = {in_full, out_full};
      A_CDAT: rd_data             = in_word;
      default: begin
        for (int k = 0; k < NSLOT; k++)
          if (rd_addr == slot_addr(k)) rd_data = wp_cfg_o[k*DATA_W +: DATA_W];
      end
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign vcat_o = vcat_q;

  assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && wr_addr == A_CTRL) |=> $stable(ctrl_q));

  assert_vcat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && wr_addr == A_VCAT) |=> $stable(vcat_q));

  assert_unimpl_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (wr_addr == 5'h03 || wr_addr[4:3] == 2'b11 || wr_addr[2:1] == 2'b11))
      |=> ($stable(ctrl_q) && $stable(vcat_q) && $stable(wp_cfg_o)));
endmodule

// File: rtl/dbg_scan_regbank.sv
module dbg_scan_regbank
  import dbg_scan_pkg::*;
#(
  parameter int NUM_WATCH = 2,
  parameter int VC_W      = 8
) (
  input  logic                                       tck,
  input  logic                                       trst_n,
  input  logic                                       sel,
  input  logic                                       capture_dr,
  input  logic                                       shift_dr,
  input  logic                                       update_dr,
  input  logic                                       tdi,
  output logic                                       tdo,
  input  logic [STAT_W-1:0]                          dbg_status_i,
  output logic [CTRL_W-1:0]                          dbg_ctrl_o,
  output logic [VC_W-1:0]                            vcat_o,
  output logic [NUM_WATCH*WORDS_PER_UNIT*DATA_W-1:0] wp_cfg_o,
  output logic                                       h2c_valid,
  input  logic                                       h2c_ready,
  output logic [DATA_W-1:0]                          h2c_data,
  input  logic                                       c2h_valid,
  output logic                                       c2h_ready,
  input  logic [DATA_W-1:0]                          c2h_data
);
  logic              wr_stb, rd_take, c2h_full, h2c_room;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data, c2h_word;
  logic              cdat_wr, cdat_rd;

  dbg_shift_chain u_chain (
    .clk(tck), .rst_n(trst_n), .sel(sel), .capture(capture_dr),
    .shift(shift_dr), .update(update_dr), .tdi(tdi), .tdo(tdo),
    .cap_data(rd_data), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_take(rd_take)
  );

  assign cdat_wr = wr_stb && (wr_addr == A_CDAT);
  assign cdat_rd = rd_take && (rd_addr == A_CDAT);

  dbg_mbox_slot #(.W(DATA_W)) u_h2c (
    .clk(tck), .rst_n(trst_n),
    .in_valid(cdat_wr), .in_ready(h2c_room), .in_data(wr_data),
    .out_valid(h2c_valid), .out_ready(h2c_ready), .out_data(h2c_data)
  );

  dbg_mbox_slot #(.W(DATA_W)) u_c2h (
    .clk(tck), .rst_n(trst_n),
    .in_valid(c2h_valid), .in_ready(c2h_ready), .in_data(c2h_data),
    .out_valid(c2h_full), .out_ready(cdat_rd), .out_data(c2h_word)
  );

  dbg_reg_file #(.NUM_WATCH(NUM_WATCH), .VC_W(VC_W)) u_regs (
    .clk(tck), .rst_n(trst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .status_i(dbg_status_i), .out_full(h2c_valid), .in_full(c2h_full),
    .in_word(c2h_word), .ctrl_o(dbg_ctrl_o), .vcat_o(vcat_o),
    .wp_cfg_o(wp_cfg_o)
  );

  assert_h2c_drop_when_full_R9: assert property (@(posedge tck) disable iff (!trst_n)
    (cdat_wr && !h2c_room && !h2c_ready) |=> (h2c_valid && $stable(h2c_data)));

  assert_c2h_drain_R10: assert property (@(posedge tck) disable iff (!trst_n)
    cdat_rd |=> c2h_ready);
endmodule

// File: tb/dbg_scan_regbank_tb.sv
module dbg_scan_regbank_tb;
  localparam int NW = 2;
  localparam int VW = 8;

  logic tck = 0, trst_n = 0, sel = 1, capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic tdo;
  logic [4:0] dbg_status_i = 0;
  logic [5:0] dbg_ctrl_o;
  logic [VW-1:0] vcat_o;
  logic [NW*6*32-1:0] wp_cfg_o;
  logic h2c_valid, h2c_ready = 0, c2h_valid = 0, c2h_ready;
  logic [31:0] h2c_data, c2h_data = 0;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 tck = ~tck;

  dbg_scan_regbank #(.NUM_WATCH(NW), .VC_W(VW)) u_dut (
    .tck(tck), .trst_n(trst_n), .sel(sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .dbg_status_i(dbg_status_i), .dbg_ctrl_o(dbg_ctrl_o), .vcat_o(vcat_o),
    .wp_cfg_o(wp_cfg_o), .h2c_valid(h2c_valid), .h2c_ready(h2c_ready),
    .h2c_data(h2c_data), .c2h_valid(c2h_valid), .c2h_ready(c2h_ready),
    .c2h_data(c2h_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic scan(input logic w, input logic [4:0] a, input logic [31:0] d,
                      output logic [37:0] o);
    logic [37:0] pk;
    pk = {w, a, d};
    @(negedge tck); capture_dr = 1;
    @(negedge tck); capture_dr = 0; shift_dr = 1;
    for (int i = 0; i < 38; i++) begin
      tdi = pk[i];
      o[i] = tdo;
      @(negedge tck);
    end
    shift_dr = 0; update_dr = 1;
    @(negedge tck); update_dr = 0;
  endtask

  // read request then a dummy write to 0x03 to bring the value out
  task automatic rd(input logic [4:0] a, output logic [31:0] v, input string req);
    logic [37:0] o;
    scan(1'b0, a, 32'h0, o);
    scan(1'b1, 5'h03, 32'h0, o);
    check({req, " echo addr/dir"}, {58'h0, o[37:32]}, {58'h0, 1'b0, a});
    v = o[31:0];
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    logic [37:0] o;
    scan(1'b1, a, d, o);
  endtask

  task automatic t_reset;
    check("R12 tdo", tdo, 0);
    check("R12 ctrl", dbg_ctrl_o, 0);
    check("R12 vcat", vcat_o, 0);
    check("R12 wp", wp_cfg_o[63:0] | wp_cfg_o[383:320], 0);
    check("R12 h2c_valid", h2c_valid, 0);
    check("R12 c2h_ready", c2h_ready, 1);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(5'h00, 32'hFFFF_FFFF);
    check("R4 R2 ctrl out", dbg_ctrl_o, 6'h3F);
    rd(5'h00, v, "R4");
    check("R4 ctrl read", v, 32'h3F);
    wr(5'h00, 32'h0000_0010);
    rd(5'h00, v, "R4");
    check("R4 monitor bit", v, 32'h10);
  endtask

  task automatic t_status;
    logic [31:0] v;
    dbg_status_i = 5'h15;
    wr(5'h01, 32'hFFFF_FFFF);
    rd(5'h01, v, "R5");
    check("R5 status read", v, 32'h15);
  endtask

  task automatic t_vcat;
    logic [31:0] v;
    wr(5'h02, 32'h1234_56A5);
    check("R6 vcat out", vcat_o, 8'hA5);
    rd(5'h02, v, "R6");
    check("R6 vcat read", v, 32'hA5);
  endtask

  task automatic t_watch;
    logic [31:0] v;
    wr(5'h08, 32'hCAFE_0001);
    wr(5'h13, 32'hDEAD_BEEF);
    wr(5'h15, 32'h0BAD_F00D);
    check("R7 slot0", wp_cfg_o[0 +: 32], 32'hCAFE_0001);
    check("R7 slot9", wp_cfg_o[9*32 +: 32], 32'hDEAD_BEEF);
    check("R7 slot11", wp_cfg_o[11*32 +: 32], 32'h0BAD_F00D);
    rd(5'h13, v, "R7");
    check("R7 R3 read unit1 data mask", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_unimpl;
    logic [31:0] v;
    logic [383:0] wp_before;
    wp_before = wp_cfg_o;
    wr(5'h03, 32'hFFFF_FFFF);
    wr(5'h0E, 32'hFFFF_FFFF);
    wr(5'h1F, 32'hFFFF_FFFF);
    check("R8 wp unchanged", wp_cfg_o == wp_before, 1);
    check("R8 vcat unchanged", vcat_o, 8'hA5);
    rd(5'h1F, v, "R8");
    check("R8 unimpl read zero", v, 0);
    rd(5'h07, v, "R8");
    check("R8 unimpl 0x07 zero", v, 0);
    sel = 0;
    wr(5'h00, 32'h2A);
    sel = 1;
    check("R8 deselected scan", dbg_ctrl_o, 6'h10);
  endtask

  task automatic t_pipe;
    logic [37:0] o;
    scan(1'b0, 5'h02, 32'h0, o);
    scan(1'b0, 5'h00, 32'h0, o);
    check("R3 first read result", o, {1'b0, 5'h02, 32'hA5});
    scan(1'b1, 5'h03, 32'h0, o);
    check("R3 second read result", o, {1'b0, 5'h00, 32'h10});
    scan(1'b1, 5'h03, 32'h0, o);
    check("R3 idle capture zero", o, 0);
    // R1: shift alignment, full packet echoed by the next dummy scan's capture? check tdo path
    @(negedge tck); shift_dr = 1;
    for (int i = 0; i < 38; i++) begin tdi = (i == 0); @(negedge tck); end
    check("R1 tdi bit0 at tdo after 38 shifts", tdo, 1);
    tdi = 0; @(negedge tck);
    check("R1 shifted one more", tdo, 0);
    shift_dr = 0;
  endtask

  task automatic t_h2c;
    logic [31:0] v;
    wr(5'h05, 32'hAAAA_5555);
    check("R9 h2c valid", h2c_valid, 1);
    check("R9 h2c data", h2c_data, 32'hAAAA_5555);
    wr(5'h05, 32'hBBBB_BBBB);
    check("R9 full write ignored", h2c_data, 32'hAAAA_5555);
    rd(5'h04, v, "R11");
    check("R11 cctl out full", v, 32'h1);
    @(negedge tck); h2c_ready = 1;
    @(negedge tck); h2c_ready = 0;
    check("R9 handshake clears", h2c_valid, 0);
  endtask

  task automatic t_c2h;
    logic [31:0] v;
    @(negedge tck); c2h_valid = 1; c2h_data = 32'h1357_9BDF;
    @(negedge tck); c2h_valid = 1; c2h_data = 32'hFFFF_0000;
    check("R10 slot full", c2h_ready, 0);
    @(negedge tck); c2h_valid = 0;
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v, "R11");
    check("R11 cctl in full", v, 32'h2);
    rd(5'h05, v, "R10");
    check("R10 read data", v, 32'h1357_9BDF);
    check("R10 slot drained", c2h_ready, 1);
    rd(5'h04, v, "R11");
    check("R11 cctl empty", v, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge tck);
    t_reset();
    trst_n = 1;
    @(negedge tck);
    t_ctrl();
    t_status();
    t_vcat();
    t_watch();
    t_unimpl();
    t_pipe();
    t_h2c();
    t_c2h();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule